// File: doc/BRIEF.md
# Low-Power Single-Input-Change Test Pattern Generator

This generator feeds test vectors to logic under self-test with as little switching as it can manage. A maximal-length shift register holds a seed vector. A binary run counter goes through a Gray converter, and the Gray value is XORed onto the seed. Inside the run that belongs to one seed, each vector therefore differs from the one before it in a single bit. When the counter wraps from its top value back to zero, the shift register takes one step to a new seed, and a new low-activity run starts from that seed.

While `enable` is high, one vector is produced per clock, with a valid strobe. Lowering `enable` freezes the whole generator. A seed load restarts the sequence from a seed chosen by the integrator. A load of zero is replaced by the built-in nonzero seed, so the shift register cannot lock up.

Top module: `sic_pattern_gen`

## Requirements
- R1: After reset `pattern_valid` is 0 and `pattern` is all zeros, the seed holds `RESET_SEED` and the run counter is 0, so the first enabled vector equals `RESET_SEED`.
- R2: Each vector equals seed XOR G, where G = c XOR (c >> 1) for the run count c. G is zero-extended into the low `RUN_BITS` bits of the `WIDTH`-bit vector.
- R3: Two vectors produced on consecutive cycles within one seed's run differ in exactly one bit position.
- R4: The seed steps exactly when an enabled cycle finds the run count at 2^`RUN_BITS`−1, and the count then returns to 0. Between two successive seed vectors, 2^`RUN_BITS`−1 further vectors are emitted.
- R5: The seed steps as a right-shifting Galois register: the next value is (s >> 1) XOR (`TAPS` if s[0] is 1, else 0). With the default `TAPS` = 8'hB8 this gives the maximal-length sequence. The seed is never all zeros.
- R6: In a cycle with `enable` low and `seed_load` low, `pattern_valid` is 0 on the following cycle, `pattern` keeps its value, and neither the seed nor the count advances.
- R7: `seed_load` takes priority over `enable`. It loads `seed_in` as the seed and clears the run count. `pattern_valid` is 0 and `pattern` is unchanged on the following cycle.
- R8: A `seed_load` whose `seed_in` is all zeros loads `RESET_SEED` in its place.
- R9: Every enabled cycle without a load yields exactly one vector with `pattern_valid` = 1 on the next cycle, and no other cycle asserts `pattern_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Produce one vector this cycle |
| seed_load | input | 1 | Load a new seed and restart the run |
| seed_in | input | WIDTH | Seed value taken on `seed_load` |
| pattern | output | WIDTH | Registered test vector |
| pattern_valid | output | 1 | `pattern` was updated by the last edge |

## Verification
A wrong run count shows up at once as a vector whose Gray part is off. It often also shows a step that flips zero bits or two bits. A seed register that steps early, late or with the wrong feedback stays hidden until the first vector of the next run. That vector is the bare seed, so the fault appears one cycle after the wrap. The bench therefore crosses several wraps and compares every vector, including the first one after each wrap, load and pause. A pause or load that leaks an advance shows up as a misaligned vector on the next enabled cycle.

// File: rtl/sicg_pkg.sv
package sicg_pkg;

  // Per-cycle control decoded from the block inputs.
  typedef struct packed {
    logic load;     // restart from a new seed
    logic advance;  // emit a vector and move the run on
  } sicg_ctrl_t;

  function automatic sicg_ctrl_t decode_ctrl(input logic enable, input logic seed_load);
    sicg_ctrl_t c;
    c.load    = seed_load;
    c.advance = enable & ~seed_load;
    return c;
  endfunction

endpackage

// File: rtl/sicg_seed_lfsr.sv
module sicg_seed_lfsr #(
  parameter int unsigned       WIDTH      = 8,
  parameter logic [WIDTH-1:0]  TAPS       = 8'hB8,
  parameter logic [WIDTH-1:0]  RESET_SEED = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step,
  output logic [WIDTH-1:0] seed
);

  // Right-shifting Galois step.
  function automatic logic [WIDTH-1:0] lfsr_next(input logic [WIDTH-1:0] s);
    return {1'b0, s[WIDTH-1:1]} ^ (s[0] ? TAPS : '0);
  endfunction

  // A zero seed would lock the register, so it is swapped for the default.
  function automatic logic [WIDTH-1:0] safe_seed(input logic [WIDTH-1:0] v);
    return (v == '0) ? RESET_SEED : v;
  endfunction

  logic             zero_load;
  logic [WIDTH-1:0] seed_d;

  assign zero_load = load && (load_val == '0);

  always_comb begin
    seed_d = seed;
    if (load)      seed_d = safe_seed(load_val);
    else if (step) seed_d = lfsr_next(seed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seed <= RESET_SEED;
    else        seed <= seed_d;
  end

  // R5
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed != '0);

  // R4
  seed_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (seed != $past(seed)));

  // R4
  seed_rests_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(seed));

  // R8
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_load |=> (seed == RESET_SEED));

endmodule

// File: rtl/sicg_run_counter.sv
module sicg_run_counter #(
  parameter int unsigned RUN_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                advance,
  output logic [RUN_BITS-1:0] count,
  output logic                wrap
);

  localparam logic [RUN_BITS-1:0] CNT_MAX = '1;

  function automatic logic [RUN_BITS-1:0] count_next(input logic [RUN_BITS-1:0] c);
    return (c == CNT_MAX) ? '0 : c + RUN_BITS'(1);
  endfunction

  // Wrap event: the cycle in which the run ends and the seed must step.
  assign wrap = advance && !clear && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (advance) count <= count_next(count);
  end

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));

  // R6
  count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clear) |=> $stable(count));

endmodule

// File: rtl/sicg_gray_mix.sv
module sicg_gray_mix #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned RUN_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [RUN_BITS-1:0] count,
  input  logic [WIDTH-1:0]    seed,
  output logic [WIDTH-1:0]    pattern,
  output logic                valid,
  output logic                run_first
);

  localparam int unsigned PAD = WIDTH - RUN_BITS;

  function automatic logic [RUN_BITS-1:0] to_gray(input logic [RUN_BITS-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [RUN_BITS-1:0] gray;
  logic [WIDTH-1:0]    gray_w;
  logic [WIDTH-1:0]    mix;

  assign gray = to_gray(count);

  generate
    if (PAD == 0) begin : g_full
      assign gray_w = gray;
    end else begin : g_pad
      assign gray_w = {{PAD{1'b0}}, gray};
    end
  endgenerate

  assign mix = seed ^ gray_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern   <= '0;
      valid     <= 1'b0;
      run_first <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) begin
        pattern   <= mix;
        run_first <= (count == '0);
      end
    end
  end

  // R3
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && !run_first) |-> ($countones(pattern ^ $past(pattern)) == 1));

endmodule

// File: rtl/sic_pattern_gen.sv
module sic_pattern_gen
  import sicg_pkg::*;
#(
  parameter int unsigned       WIDTH      = 8,
  parameter int unsigned       RUN_BITS   = 8,
  parameter logic [WIDTH-1:0]  TAPS       = 8'hB8,
  parameter logic [WIDTH-1:0]  RESET_SEED = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_in,
  output logic [WIDTH-1:0] pattern,
  output logic             pattern_valid
);

  sicg_ctrl_t          ctrl;
  logic [RUN_BITS-1:0] run_count;
  logic                run_wrap;
  logic [WIDTH-1:0]    seed;
  logic                run_first;

  assign ctrl = decode_ctrl(enable, seed_load);

  sicg_run_counter #(.RUN_BITS(RUN_BITS)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ctrl.load),
    .advance (ctrl.advance),
    .count   (run_count),
    .wrap    (run_wrap)
  );

  sicg_seed_lfsr #(.WIDTH(WIDTH), .TAPS(TAPS), .RESET_SEED(RESET_SEED)) u_seed (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctrl.load),
    .load_val (seed_in),
    .step     (run_wrap),
    .seed     (seed)
  );

  sicg_gray_mix #(.WIDTH(WIDTH), .RUN_BITS(RUN_BITS)) u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (ctrl.advance),
    .count     (run_count),
    .seed      (seed),
    .pattern   (pattern),
    .valid     (pattern_valid),
    .run_first (run_first)
  );

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !seed_load) |=> (!pattern_valid && $stable(pattern)));

  // R7
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (!pattern_valid && $stable(pattern) && run_count == '0));

  // R9
  valid_follows_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !seed_load) |=> pattern_valid);

endmodule

// File: tb/sic_pattern_gen_bench.sv
module sic_pattern_gen_bench;

  localparam int   W          = 8;
  localparam int   RB         = 8;
  localparam int   CLK_PERIOD = 10;
  localparam logic [W-1:0] TAPS_B  = 8'hB8;  // x^8+x^6+x^5+x^4+1
  localparam logic [W-1:0] SEED0_B = 8'h5A;
  localparam int   RUN_LEN    = 1 << RB;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         seed_load = 1'b0;
  logic [W-1:0] seed_in = '0;
  logic [W-1:0] pattern;
  logic         pattern_valid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sic_pattern_gen #(.WIDTH(W), .RUN_BITS(RB), .TAPS(TAPS_B), .RESET_SEED(SEED0_B)) u_sic_pattern_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .seed_load(seed_load),
    .seed_in(seed_in), .pattern(pattern), .pattern_valid(pattern_valid)
  );

  typedef struct {
    logic [W-1:0] val;
    bit           first;
    string        tag;
  } exp_t;
  exp_t exp_q[$];

  // Reference model state
  logic [W-1:0] m_seed = SEED0_B;
  int           m_cnt = 0;
  string        m_next_tag = "R1";

  function automatic logic [W-1:0] ref_gray(input int c);
    logic [W-1:0] g;
    for (int i = 0; i < W; i++) begin
      g[i] = (i < RB) ? (((c >> i) & 1) != ((c >> (i + 1)) & 1)) : 1'b0;
    end
    return g;
  endfunction

  function automatic logic [W-1:0] ref_step(input logic [W-1:0] s);
    logic [W-1:0] n;
    for (int i = 0; i < W; i++) begin
      n[i] = ((i == W - 1) ? 1'b0 : s[i+1]) ^ (s[0] & TAPS_B[i]);
    end
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected item.
  task automatic drive(input bit en, input bit ld, input logic [W-1:0] val);
    exp_t e;
    @(negedge clk);
    enable = en;
    seed_load = ld;
    seed_in = val;
    if (ld) begin
      m_seed = (val == '0) ? SEED0_B : val;
      m_cnt = 0;
      m_next_tag = (val == '0) ? "R8" : "R7";
    end else if (en) begin
      e.val = m_seed ^ ref_gray(m_cnt);
      e.first = (m_cnt == 0);
      e.tag = e.first ? m_next_tag : "R2";
      exp_q.push_back(e);
      if (m_cnt == RUN_LEN - 1) begin
        m_cnt = 0;
        m_seed = ref_step(m_seed);
        m_next_tag = "R4";
      end else begin
        m_cnt++;
      end
    end
  endtask

  // Monitor
  logic [W-1:0] prev_pat = '0;
  bit           prev_valid = 1'b0;
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (pattern_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected valid", pattern, '0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(pattern == e.val, e.tag, pattern, e.val);
          if (prev_valid && !e.first)
            check($countones(pattern ^ prev_pat) == 1, "R3 one-bit step", pattern ^ prev_pat, '0);
          if (e.first)
            check(pattern != '0, "R5 seed nonzero", pattern, e.val);
        end
      end else begin
        check(pattern == prev_pat, "R6 hold", pattern, prev_pat);
      end
      prev_valid = pattern_valid;
      prev_pat = pattern;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(pattern_valid == 1'b0, "R1 valid after reset", {{(W-1){1'b0}}, pattern_valid}, '0);
    check(pattern == '0, "R1 pattern after reset", pattern, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // Long run across a wrap: R2, R3, R4, R5
    for (int i = 0; i < RUN_LEN + 40; i++) drive(1'b1, 1'b0, '0);
    // Pause: R6
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, '0);
    // Alternating enable
    for (int i = 0; i < 20; i++) drive(i[0], 1'b0, '0);
    // Load a seed: R7
    drive(1'b0, 1'b1, 8'h3C);
    for (int i = 0; i < 30; i++) drive(1'b1, 1'b0, '0);
    // Zero load together with enable: R7 priority, R8
    drive(1'b1, 1'b1, 8'h00);
    for (int i = 0; i < RUN_LEN + 10; i++) drive(1'b1, 1'b0, '0);
    // Load with enable, then a second wrap
    drive(1'b1, 1'b1, 8'h01);
    for (int i = 0; i < RUN_LEN + 5; i++) drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
    repeat (3) @(posedge clk);
    #2;
    // R9: every enabled cycle gave exactly one vector
    check(exp_q.size() == 0, "R9 all vectors seen", W'(exp_q.size()), '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule